// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a host processor. Three separate 8-bit state registers are kept: pending requests, masks, and levels currently in service. A combinational resolver finds the best eligible pending line. It raises the interrupt output only when that line outranks everything already in service. Line 0 has the highest priority and line 7 the lowest.

The host reaches the block through an 8-bit register port. The port is qualified by an active-low chip select and active-low read and write strobes. Through it the host programs the mask, the trigger style and a vector base, reads the pending and in-service registers, and issues end-of-interrupt commands. A one-cycle acknowledge pulse moves the winning line from pending into service. It also latches a vector code that combines the programmed base with the line number.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_out is 0 and vec_out is 0x00. The mask reads 0xFF, the config register reads 0x00 (level style, base 0), and the pending and in-service registers read 0x00.
- R2: Register select is addr: 0 = mask (read/write), 1 = config (read/write; bit 0 = 1 for edge style, bits 7:3 = vector base, bits 2:1 read 0), 2 = write command / read pending, 3 = read in-service (writes ignored). A write takes effect at the clock edge where cs_n=0 and wr_n=0. rdata shows the selected register while cs_n=0 and rd_n=0, and is 0x00 otherwise. Writes with cs_n=1 change nothing.
- R3: A line whose mask bit is 1 never raises irq_out and is never moved into service, even when its pending bit is set.
- R4: Among unmasked pending lines, the lowest line number wins the acknowledge.
- R5: irq_out is 1 exactly when some unmasked pending line has a lower number than every line in service. A line in service blocks itself and every higher-numbered line.
- R6: In edge style, a pending bit is set one cycle after a rising edge on its input. It stays set after the input falls, and clears only on acknowledge. A line held high after acknowledge does not become pending again.
- R7: In level style, a pending bit follows its input with one cycle of delay. It clears without any acknowledge when the input falls.
- R8: An acknowledge while irq_out=1 sets the winner's in-service bit and clears its pending bit. It loads vec_out with {base, line number[2:0]} on the next cycle. vec_out holds that value until the next acknowledge.
- R9: A write to address 2 with data bit 0 = 1 clears the lowest-numbered set in-service bit. Such a write with bit 0 = 0 has no effect.
- R10: An acknowledge while irq_out=0 loads vec_out with {base, 3'b111} and changes neither the pending nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request lines, bit 0 highest priority |
| cs_n | input | 1 | Active-low chip select for register access |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is active |
| ack | input | 1 | One-cycle interrupt acknowledge from host |
| irq_out | output | 1 | Interrupt request to host |
| vec_out | output | 8 | Vector code latched on acknowledge |

## Verification
A wrong pending, mask or in-service bit shows on irq_out in the same cycle the register holds it, because the output is a combinational function of those three registers. It shows on vec_out and on the pending or in-service readback one cycle after the next acknowledge. A nested sequence is the main probe: higher-priority arrivals must break through an active level, lower ones must stay held off, and each end-of-interrupt must reopen exactly one level. If any in-service bit is dropped or doubled, the irq_out pattern of that sequence goes wrong within a cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_SVC  = 2'd3
  } reg_sel_e;

  localparam int CFG_EDGE_BIT = 0;
  localparam int CMD_EOI_BIT  = 0;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_mode,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pending
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = req_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q <= req_in;
      if (edge_mode) pending <= (pending | rise) & ~ack_clr;
      else           pending <= req_in & ~ack_clr;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pending,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     isr,
  output logic             grant_ok,
  output logic [IDX_W-1:0] cand_idx
);
  function automatic logic [IDX_W-1:0] first_set(input logic [N-1:0] v);
    first_set = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) first_set = IDX_W'(i);
    end
  endfunction

  logic [N-1:0]     eligible;
  logic [IDX_W-1:0] svc_idx;

  assign eligible = pending & ~mask;
  assign cand_idx = first_set(eligible);
  assign svc_idx  = first_set(isr);
  assign grant_ok = (|eligible) && (~|isr || cand_idx < svc_idx);
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] grant_set,
  input  logic         eoi,
  output logic [N-1:0] isr
);
  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    lowest_bit = v & (~v + N'(1));
  endfunction

  logic [N-1:0] eoi_clr;
  assign eoi_clr = eoi ? lowest_bit(isr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~eoi_clr) | grant_set;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int DATA_W = NUM_IRQ,
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IRQ-1:0] req_in,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack,
  output logic              irq_out,
  output logic [DATA_W-1:0] vec_out
);
  import irq_prio_pkg::*;

  logic [NUM_IRQ-1:0] mask_q;
  logic               edge_q;
  logic [BASE_W-1:0]  base_q;
  logic [DATA_W-1:0]  vec_q;
  logic [NUM_IRQ-1:0] pending_q;
  logic [NUM_IRQ-1:0] isr_q;
  logic [NUM_IRQ-1:0] grant_set;
  logic [IDX_W-1:0]   cand_idx;
  logic               grant_ok;
  logic               wr_en;
  logic               rd_en;
  logic               eoi_pulse;
  logic               take;
  reg_sel_e           sel;

  assign sel       = reg_sel_e'(addr);
  assign wr_en     = !cs_n && !wr_n;
  assign rd_en     = !cs_n && !rd_n;
  assign eoi_pulse = wr_en && sel == SEL_CMD && wdata[CMD_EOI_BIT];
  assign take      = ack && grant_ok;
  assign grant_set = take ? (NUM_IRQ'(1) << cand_idx) : '0;

  irq_req_capture #(.N(NUM_IRQ)) u_cap (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_q), .req_in(req_in),
    .ack_clr(grant_set), .pending(pending_q)
  );

  irq_prio_pick #(.N(NUM_IRQ)) u_pick (
    .pending(pending_q), .mask(mask_q), .isr(isr_q),
    .grant_ok(grant_ok), .cand_idx(cand_idx)
  );

  irq_svc_track #(.N(NUM_IRQ)) u_svc (
    .clk(clk), .rst_n(rst_n), .grant_set(grant_set), .eoi(eoi_pulse), .isr(isr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      edge_q <= 1'b0;
      base_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MASK) mask_q <= wdata;
      if (sel == SEL_CFG) begin
        edge_q <= wdata[CFG_EDGE_BIT];
        base_q <= wdata[DATA_W-1:IDX_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_q <= '0;
    else if (ack)   vec_q <= {base_q, take ? cand_idx : {IDX_W{1'b1}}};
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_MASK: rdata = mask_q;
        SEL_CFG:  rdata = {base_q, {(IDX_W-1){1'b0}}, edge_q};
        SEL_CMD:  rdata = pending_q;
        SEL_SVC:  rdata = isr_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq_out = grant_ok;
  assign vec_out = vec_q;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack,
  input logic         eoi,
  input logic         irq_out,
  input logic [N-1:0] pending,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask,
  input logic [N-1:0] vec_out
);
  a_r5_irq_needs_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(pending & ~mask)));

  a_r8_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !eoi) |=> $countones(isr) == $countones($past(isr)) + 1);

  a_r3_masked_not_served: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> ((isr & ~$past(isr)) & $past(mask)) == '0);

  a_r8_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> (pending & isr & ~$past(isr)) == '0);

  a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack) |=> $countones(isr) == $countones($past(isr)) - (($past(isr) != '0) ? 1 : 0));

  a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec_out));

  a_r10_spurious_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !eoi) |=> $stable(isr));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi_pulse), .irq_out(irq_out),
  .pending(pending_q), .isr(isr_q), .mask(mask_q), .vec_out(vec_out)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic       irq_out;
  logic [7:0] vec_out;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack), .irq_out(irq_out), .vec_out(vec_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input logic strobe_n = 1'b0);
    @(negedge clk);
    cs_n = 1'b0; rd_n = strobe_n; addr = a;
    #1 d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk);
    req_in = v;
    @(negedge clk);
  endtask

  task automatic pulse_ack;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] d = 8'h01);
    wr(2'd2, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'b0, irq_out}, 8'h00);
    check("R1 vec", vec_out, 8'h00);
    rd(2'd0, d); check("R1 mask", d, 8'hFF);
    rd(2'd1, d); check("R1 cfg", d, 8'h00);
    rd(2'd2, d); check("R1 pending", d, 8'h00);
    rd(2'd3, d); check("R1 svc", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(2'd0, 8'h3C, 1'b1);
    rd(2'd0, d); check("R2 write without select", d, 8'hFF);
    wr(2'd0, 8'hA5);
    rd(2'd0, d); check("R2 mask write", d, 8'hA5);
    rd(2'd0, d, 1'b1); check("R2 no strobe", d, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R2 cfg unused bits", d, 8'hF9);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R2 svc write ignored", d, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr(2'd1, 8'hA1);
    @(negedge clk); req_in = 8'h08;
    @(negedge clk); req_in = 8'h00;
    @(negedge clk);
    rd(2'd2, d); check("R6 pending held", d, 8'h08);
    check("R6 irq", {7'b0, irq_out}, 8'h01);
    pulse_ack;
    check("R8 vec edge", vec_out, 8'hA3);
    rd(2'd3, d); check("R8 svc", d, 8'h08);
    rd(2'd2, d); check("R8 pending cleared", d, 8'h00);
    eoi();
    set_req(8'h10);
    pulse_ack;
    check("R6 vec", vec_out, 8'hA4);
    @(negedge clk);
    rd(2'd2, d); check("R6 held line not re-pending", d, 8'h00);
    eoi();
    set_req(8'h00);
    rd(2'd3, d); check("R9 svc empty", d, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(2'd1, 8'hA0);
    set_req(8'h04);
    rd(2'd2, d); check("R7 pending follows", d, 8'h04);
    set_req(8'h00);
    rd(2'd2, d); check("R7 pending drops", d, 8'h00);
    check("R7 irq drops", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_nest;
    logic [7:0] d;
    set_req(8'h60);
    check("R4 irq", {7'b0, irq_out}, 8'h01);
    pulse_ack;
    check("R4 vec line5", vec_out, 8'hA5);
    check("R5 lower blocked", {7'b0, irq_out}, 8'h00);
    set_req(8'h62);
    check("R5 higher breaks through", {7'b0, irq_out}, 8'h01);
    pulse_ack;
    check("R4 vec line1", vec_out, 8'hA1);
    rd(2'd3, d); check("R8 nested svc", d, 8'h22);
    set_req(8'h40);
    eoi(8'h00);
    rd(2'd3, d); check("R9 bit0 clear no effect", d, 8'h22);
    eoi();
    rd(2'd3, d); check("R9 lowest cleared", d, 8'h20);
    check("R5 still blocked", {7'b0, irq_out}, 8'h00);
    eoi();
    check("R5 reopened", {7'b0, irq_out}, 8'h01);
    pulse_ack;
    check("R8 vec line6", vec_out, 8'hA6);
    set_req(8'h00);
    eoi();
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(2'd0, 8'h01);
    set_req(8'h01);
    rd(2'd2, d); check("R3 pending while masked", d, 8'h01);
    check("R3 irq masked", {7'b0, irq_out}, 8'h00);
    pulse_ack;
    check("R10 spurious vec", vec_out, 8'hA7);
    rd(2'd3, d); check("R10 svc unchanged", d, 8'h00);
    rd(2'd2, d); check("R10 pending unchanged", d, 8'h01);
    wr(2'd0, 8'h00);
    check("R3 unmasked irq", {7'b0, irq_out}, 8'h01);
    pulse_ack;
    check("R8 vec line0", vec_out, 8'hA0);
    set_req(8'h00);
    eoi();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_nest();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule